// File: doc/BRIEF.md
# Digital Black Level Correction Loop

This block keeps the black level of a 10-bit imaging sample stream at a programmed target code. During a clamp window it collects a power-of-two number of converter samples taken from optical black pixels and forms their average with a right shift. It subtracts that average from the target and divides the error by a selectable power of two. It then adds the result into a saturating signed offset word. That word drives an offset DAC ahead of the gain stage. Each completed window produces one offset update and a one-cycle done pulse.

The clamp window comes from one of two sources. With internal generation selected, the window opens a fixed 10 clocks after the line clamp input falls. It closes once the programmed number of samples has been taken. With internal generation off, the external clamp input marks the black samples directly. When automatic correction is disabled, the loop is idle and the offset word holds whatever a host last wrote into it.

The window controller is a state machine with five states. ST_IDLE waits for a trigger. It goes to ST_DELAY on a line clamp fall in internal mode. In external mode it goes to ST_ACTIVE on the first sample with the external clamp high. ST_DELAY counts the 10-clock delay and then goes to ST_ACTIVE. ST_ACTIVE collects samples. It goes to ST_UPDATE after the last sample. In external mode it returns to ST_IDLE if the clamp drops early. ST_UPDATE lasts one cycle and commits the offset. It returns to ST_IDLE in internal mode and enters ST_HOLD in external mode. ST_HOLD waits for the external clamp to go low and then returns to ST_IDLE. Clearing the automatic enable sends every state to ST_IDLE.

Top module: `blc_loop`

## Requirements
- R1: After reset, offset_code is 0, clamp_win and upd_done are low, the target register is 0, and the control register has internal window selected, automatic correction off, scale code 00 and count code 00.
- R2: A write with cfg_we high loads the register at cfg_addr from cfg_wdata on the next rising edge. Address 0 is the 10-bit target. Address 1 is control: bit 0 is the automatic enable, bit 1 selects the internal window, bits 3:2 hold the scale code and bits 5:4 hold the count code. Address 2 is the offset. A write to address 3 has no effect.
- R3: With internal window and automatic correction on, the rising edge that first samples line_clamp low after it was high starts a delay. clamp_win goes high after the 10th rising edge following that edge.
- R4: Count codes 00, 01, 10 and 11 select 16, 32, 64 and 128 samples. clamp_win stays high for exactly that many cycles, one sample is taken on each of those edges, and the average is the sum shifted right by log2 of the count.
- R5: In external mode, every cycle in which ext_clamp is high takes one sample while the loop is idle or collecting. clamp_win follows ext_clamp in those cycles. After the programmed count, no further samples are taken until ext_clamp goes low. A run that ends before the count is reached is discarded and gives no update.
- R6: The error is the target minus the average. Scale codes 00, 01, 10 and 11 shift it arithmetically right by 0, 1, 2 and 4 bits, which rounds toward minus infinity.
- R7: The new offset is the old offset plus the scaled error, saturated to the range -512 to 511 and presented as two's complement on offset_code. It appears on the rising edge after the edge that takes the final sample.
- R8: upd_done is high for exactly one cycle with each automatic update. offset_code changes only on such an update or on an accepted host write.
- R9: With automatic correction off, no window opens and no done pulse occurs. A write to address 2 sets offset_code on the next edge, and the value is held after that.
- R10: A write to address 2 while automatic correction is on is ignored.
- R11: line_clamp has no effect in external mode, and ext_clamp has no effect in internal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_data | input | 10 | Converter sample, unsigned |
| line_clamp | input | 1 | Line clamp input; its falling edge triggers the internal window |
| ext_clamp | input | 1 | External black clamp, used in external mode |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 10 | Register write data |
| offset_code | output | 10 | Signed offset word for the offset DAC |
| clamp_win | output | 1 | High in each cycle whose sample enters the average |
| upd_done | output | 1 | One-cycle pulse on each offset update |

## Verification
The assertions assume that the control register is not rewritten while a window is open. They also assume that cfg_we does not target the offset in the same cycle as an update. Configuration is only rewritten while the loop sits in ST_IDLE, and the stimulus respects this: it waits out every window and its done pulse before writing again. It keeps line_clamp high for several cycles before each fall, so that the fall is seen cleanly. Random sample values, targets, scale codes and count codes are mixed with directed cases for rounding toward minus infinity, both saturation limits and discarded external runs.

// File: rtl/blc_pkg.sv
package blc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DELAY,
        ST_ACTIVE,
        ST_UPDATE,
        ST_HOLD
    } win_state_t;

    // control register layout, MSB first
    typedef struct packed {
        logic [1:0] cnt_sel;
        logic [1:0] scale_sel;
        logic       int_win;
        logic       auto_en;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] ADDR_TARGET = 2'd0;
    localparam logic [1:0] ADDR_CTRL   = 2'd1;
    localparam logic [1:0] ADDR_OFFSET = 2'd2;

    // right-shift amount applied to the black level error
    function automatic int unsigned scale_shift(input logic [1:0] code);
        unique case (code)
            2'b00:   scale_shift = 0;
            2'b01:   scale_shift = 1;
            2'b10:   scale_shift = 2;
            default: scale_shift = 4;
        endcase
    endfunction

endpackage

// File: rtl/blc_regs.sv
module blc_regs
    import blc_pkg::*;
#(
    parameter int unsigned DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] target_o,
    output ctrl_t             ctrl_o,
    output logic              man_wr_o,
    output logic [DATA_W-1:0] man_data_o
);

    localparam ctrl_t CTRL_RST = '{cnt_sel: 2'b00, scale_sel: 2'b00,
                                   int_win: 1'b1, auto_en: 1'b0};

    logic [DATA_W-1:0] target_q;
    ctrl_t             ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target_q <= '0;
            ctrl_q   <= CTRL_RST;
        end else if (wr_en_i) begin
            if (wr_addr_i == ADDR_TARGET) target_q <= wr_data_i;
            if (wr_addr_i == ADDR_CTRL)   ctrl_q   <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
        end
    end

    // host offset writes only land while the loop is not in control
    assign man_wr_o   = wr_en_i && (wr_addr_i == ADDR_OFFSET) && !ctrl_q.auto_en;
    assign man_data_o = wr_data_i;
    assign target_o   = target_q;
    assign ctrl_o     = ctrl_q;

endmodule

// File: rtl/blc_window.sv
module blc_window
    import blc_pkg::*;
#(
    parameter int unsigned DATA_W  = 10,
    parameter int unsigned DLY_CYC = 10,
    parameter int unsigned LOG_MIN = 4,
    parameter int unsigned SEL_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] smp_i,
    input  logic              line_clamp_i,
    input  logic              ext_clamp_i,
    input  logic              auto_en_i,
    input  logic              int_win_i,
    input  logic [SEL_W-1:0]  cnt_sel_i,
    output logic              win_o,
    output logic              upd_req_o,
    output logic [DATA_W-1:0] avg_o
);

    localparam int unsigned LOG_MAX = LOG_MIN + (1 << SEL_W) - 1;
    localparam int unsigned PCNT_W  = LOG_MAX;
    localparam int unsigned ACC_W   = DATA_W + LOG_MAX;
    localparam int unsigned DCNT_W  = $clog2(DLY_CYC + 1);

    win_state_t        state_q, state_n;
    logic              lc_q;
    logic              lc_fall;
    logic              take;
    logic [DCNT_W-1:0] dcnt_q;
    logic [PCNT_W-1:0] pcnt_q;
    logic [ACC_W-1:0]  acc_q;
    logic [PCNT_W:0]   n_pix;
    logic [PCNT_W-1:0] n_last;
    logic [ACC_W-1:0]  acc_sh;
    logic              last_smp;

    assign n_pix   = {{PCNT_W{1'b0}}, 1'b1} << (LOG_MIN + 32'(cnt_sel_i));
    assign n_last  = n_pix[PCNT_W-1:0] - {{(PCNT_W-1){1'b0}}, 1'b1};
    assign lc_fall = lc_q && !line_clamp_i;
    assign last_smp = (pcnt_q == n_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lc_q <= 1'b0;
        else        lc_q <= line_clamp_i;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // next state and sample strobe
    always_comb begin
        state_n = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (int_win_i) begin
                    if (lc_fall) state_n = ST_DELAY;
                end else if (ext_clamp_i) begin
                    take    = 1'b1;
                    state_n = ST_ACTIVE;
                end
            end
            ST_DELAY: begin
                if (dcnt_q == DCNT_W'(DLY_CYC)) state_n = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (int_win_i || ext_clamp_i) begin
                    take = 1'b1;
                    if (last_smp) state_n = ST_UPDATE;
                end else begin
                    state_n = ST_IDLE;
                end
            end
            ST_UPDATE: begin
                state_n = int_win_i ? ST_IDLE : ST_HOLD;
            end
            ST_HOLD: begin
                if (!ext_clamp_i) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
        if (!auto_en_i) begin
            state_n = ST_IDLE;
            take    = 1'b0;
        end
    end

    // counters and accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcnt_q <= '0;
            pcnt_q <= '0;
            acc_q  <= '0;
        end else begin
            if (state_q == ST_DELAY) dcnt_q <= dcnt_q + 1'b1;
            else                     dcnt_q <= DCNT_W'(1);
            if (state_q == ST_IDLE || state_q == ST_DELAY) begin
                pcnt_q <= take ? PCNT_W'(1) : '0;
                acc_q  <= take ? ACC_W'(smp_i) : '0;
            end else if (take) begin
                pcnt_q <= pcnt_q + 1'b1;
                acc_q  <= acc_q + ACC_W'(smp_i);
            end
        end
    end

    // outputs
    always_comb begin
        acc_sh    = acc_q >> (LOG_MIN + 32'(cnt_sel_i));
        avg_o     = acc_sh[DATA_W-1:0];
        win_o     = take;
        upd_req_o = (state_q == ST_UPDATE) && auto_en_i;
    end

    // R4
    win_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE) |-> (pcnt_q <= n_last));

    // R3
    delay_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DELAY) |-> (dcnt_q <= DCNT_W'(DLY_CYC)));

    // R9
    auto_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en_i |=> (state_q == ST_IDLE));

endmodule

// File: rtl/blc_integ.sv
module blc_integ
    import blc_pkg::*;
#(
    parameter int unsigned DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_req_i,
    input  logic [DATA_W-1:0] avg_i,
    input  logic [DATA_W-1:0] target_i,
    input  logic [1:0]        scale_sel_i,
    input  logic              man_wr_i,
    input  logic [DATA_W-1:0] man_data_i,
    output logic [DATA_W-1:0] offset_o,
    output logic              done_o
);

    localparam int unsigned SUM_W = DATA_W + 2;
    localparam logic signed [SUM_W-1:0] OFF_MAX = SUM_W'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] OFF_MIN = ~OFF_MAX;

    logic [DATA_W-1:0]        offset_q;
    logic                     done_q;
    logic signed [DATA_W:0]   err;
    logic signed [DATA_W:0]   scaled;
    logic signed [SUM_W-1:0]  sum;
    logic [DATA_W-1:0]        off_n;

    always_comb begin
        err    = $signed({1'b0, target_i}) - $signed({1'b0, avg_i});
        scaled = err >>> scale_shift(scale_sel_i);
        sum    = $signed({{2{offset_q[DATA_W-1]}}, offset_q})
               + $signed({scaled[DATA_W], scaled});
        if (sum > OFF_MAX)      off_n = OFF_MAX[DATA_W-1:0];
        else if (sum < OFF_MIN) off_n = OFF_MIN[DATA_W-1:0];
        else                    off_n = sum[DATA_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offset_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= upd_req_i && !man_wr_i;
            if (man_wr_i)       offset_q <= man_data_i;
            else if (upd_req_i) offset_q <= off_n;
        end
    end

    assign offset_o = offset_q;
    assign done_o   = done_q;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R8
    offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(offset_q) |-> ($past(upd_req_i) || $past(man_wr_i)));

endmodule

// File: rtl/blc_loop.sv
module blc_loop
    import blc_pkg::*;
#(
    parameter int unsigned DATA_W  = 10,
    parameter int unsigned DLY_CYC = 10,
    parameter int unsigned LOG_MIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              line_clamp,
    input  logic              ext_clamp,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] offset_code,
    output logic              clamp_win,
    output logic              upd_done
);

    ctrl_t             ctrl;
    logic [DATA_W-1:0] target;
    logic              man_wr;
    logic [DATA_W-1:0] man_data;
    logic              upd_req;
    logic [DATA_W-1:0] avg;

    blc_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (cfg_we),
        .wr_addr_i  (cfg_addr),
        .wr_data_i  (cfg_wdata),
        .target_o   (target),
        .ctrl_o     (ctrl),
        .man_wr_o   (man_wr),
        .man_data_o (man_data)
    );

    blc_window #(
        .DATA_W  (DATA_W),
        .DLY_CYC (DLY_CYC),
        .LOG_MIN (LOG_MIN),
        .SEL_W   (2)
    ) u_window (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_i        (smp_data),
        .line_clamp_i (line_clamp),
        .ext_clamp_i  (ext_clamp),
        .auto_en_i    (ctrl.auto_en),
        .int_win_i    (ctrl.int_win),
        .cnt_sel_i    (ctrl.cnt_sel),
        .win_o        (clamp_win),
        .upd_req_o    (upd_req),
        .avg_o        (avg)
    );

    blc_integ #(.DATA_W(DATA_W)) u_integ (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_req_i   (upd_req),
        .avg_i       (avg),
        .target_i    (target),
        .scale_sel_i (ctrl.scale_sel),
        .man_wr_i    (man_wr),
        .man_data_i  (man_data),
        .offset_o    (offset_code),
        .done_o      (upd_done)
    );

endmodule

// File: tb/blc_loop_tb.sv
module blc_loop_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] smp_data = '0;
    logic       line_clamp = 1'b0;
    logic       ext_clamp = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [9:0] cfg_wdata = '0;
    logic [9:0] offset_code;
    logic       clamp_win;
    logic       upd_done;

    int n_chk = 0;
    int n_bad = 0;
    int exp_off = 0;
    int cur_tgt = 0;
    int cur_cnt = 0;
    int cur_sc = 0;

    always #2 clk = ~clk;

    blc_loop u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_data    (smp_data),
        .line_clamp  (line_clamp),
        .ext_clamp   (ext_clamp),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .offset_code (offset_code),
        .clamp_win   (clamp_win),
        .upd_done    (upd_done)
    );

    function automatic int next_off(input int off, input int tgt, input int avg, input int sc);
        int e;
        int s;
        e = tgt - avg;
        e = e >>> ((sc == 3) ? 4 : sc);
        s = off + e;
        if (s > 511) s = 511;
        if (s < -512) s = -512;
        return s;
    endfunction

    function automatic int off_now();
        return int'($signed(offset_code));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [9:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_ctrl(input int cnt, input int sc, input int intw, input int auto_on);
        cur_cnt = cnt;
        cur_sc  = sc;
        wr(2'd1, 10'((cnt << 4) | (sc << 2) | (intw << 1) | auto_on));
    endtask

    task automatic set_tgt(input int t);
        cur_tgt = t;
        wr(2'd0, 10'(t));
    endtask

    function automatic int pick(input int lo, input int hi);
        return lo + int'($urandom % (hi - lo + 1));
    endfunction

    // internal window: line clamp fall, then N samples, then one update
    task automatic run_int(input int lo, input int hi, input bit ext_noise);
        int n = 16 << cur_cnt;
        int sum = 0;
        int wcnt = 0;
        int first = -1;
        int dones = 0;
        int done_at = -1;
        int d;
        line_clamp = 1'b1;
        repeat (3) @(negedge clk);
        line_clamp = 1'b0;
        for (int i = 1; i <= n + 14; i++) begin
            @(negedge clk);
            if (clamp_win) begin
                if (first < 0) first = i;
                wcnt++;
            end
            if (upd_done) begin
                dones++;
                done_at = i;
            end
            d = pick(lo, hi);
            smp_data = 10'(d);
            if (clamp_win) sum += d;
            ext_clamp = ext_noise ? 1'($urandom % 2) : 1'b0;
        end
        ext_clamp = 1'b0;
        exp_off = next_off(exp_off, cur_tgt, sum >> (4 + cur_cnt), cur_sc);
        chk("R3 window start negedge", first, 11);
        chk(ext_noise ? "R11 R4 window length" : "R4 window length", wcnt, n);
        chk("R8 done pulses", dones, 1);
        chk("R7 update cycle", done_at, n + 12);
        chk("R6 R7 offset", off_now(), exp_off);
    endtask

    // external window, optionally preceded by a short discarded run
    task automatic run_ext(input int lo, input int hi, input int partial);
        int n = 16 << cur_cnt;
        int sum = 0;
        int wcnt = 0;
        int dones = 0;
        int done_at = -1;
        int d;
        for (int i = 0; i < partial; i++) begin
            @(negedge clk);
            ext_clamp = 1'b1;
            smp_data = 10'(pick(lo, hi));
            #1;
            if (upd_done) dones++;
        end
        repeat (2) begin
            @(negedge clk);
            ext_clamp = 1'b0;
            #1;
            if (upd_done) dones++;
        end
        chk("R5 short run discarded", dones, 0);
        chk("R5 short run offset", off_now(), exp_off);
        for (int i = 1; i <= n + 4; i++) begin
            @(negedge clk);
            ext_clamp = 1'b1;
            d = pick(lo, hi);
            smp_data = 10'(d);
            #1;
            if (clamp_win) begin
                sum += d;
                wcnt++;
            end
            if (upd_done) begin
                dones++;
                done_at = i;
            end
        end
        repeat (2) begin
            @(negedge clk);
            ext_clamp = 1'b0;
            #1;
            if (upd_done) dones++;
        end
        exp_off = next_off(exp_off, cur_tgt, sum >> (4 + cur_cnt), cur_sc);
        chk("R5 external sample count", wcnt, n);
        chk("R5 external done pulses", dones, 1);
        chk("R5 external update cycle", done_at, n + 2);
        chk("R5 R7 external offset", off_now(), exp_off);
    endtask

    // a line clamp fall that must open no window
    task automatic quiet_fall(input string tag, input int cycles);
        int wins = 0;
        int dones = 0;
        line_clamp = 1'b1;
        repeat (3) @(negedge clk);
        line_clamp = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (clamp_win) wins++;
            if (upd_done) dones++;
        end
        chk({tag, " window"}, wins, 0);
        chk({tag, " done"}, dones, 0);
        chk({tag, " offset"}, off_now(), exp_off);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int t;
        void'($urandom(32'd5177));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 offset", off_now(), 0);
        chk("R1 clamp_win", int'(clamp_win), 0);
        chk("R1 upd_done", int'(upd_done), 0);

        // R9 auto off by default: a line clamp fall opens no window
        quiet_fall("R9 R1 auto off", 200);

        // R9 manual offset write
        wr(2'd2, 10'h3C5);
        exp_off = -59;
        chk("R9 manual offset", off_now(), -59);
        // R2 address 3 has no effect
        wr(2'd3, 10'h155);
        chk("R2 addr3 ignored", off_now(), -59);

        // R10 offset write ignored while automatic correction is on
        set_ctrl(0, 0, 1, 1);
        wr(2'd2, 10'd100);
        chk("R10 offset write ignored", off_now(), -59);

        // R2 R3 R4 R6 R7 random internal windows
        for (int k = 0; k < 8; k++) begin
            t = pick(0, 1023);
            set_tgt(t);
            set_ctrl(k % 4, pick(0, 3), 1, 1);
            begin
                int lo = pick(0, 900);
                run_int(lo, lo + 100, k == 2);
            end
        end

        // R6 rounding toward minus infinity: error -3 at scale 11 gives -1
        set_ctrl(0, 0, 1, 0);
        wr(2'd2, 10'd0);
        exp_off = 0;
        set_tgt(100);
        set_ctrl(0, 3, 1, 1);
        run_int(103, 103, 1'b0);
        chk("R6 floor rounding", off_now(), -1);

        // R7 positive and negative saturation
        set_tgt(1023);
        set_ctrl(1, 0, 1, 1);
        run_int(0, 0, 1'b0);
        chk("R7 upper limit", off_now(), 511);
        run_int(0, 0, 1'b0);
        chk("R7 upper limit held", off_now(), 511);
        set_tgt(0);
        run_int(1023, 1023, 1'b0);
        chk("R7 lower limit", off_now(), -512);

        // R5 R11 external mode
        set_tgt(pick(200, 400));
        set_ctrl(1, 1, 0, 1);
        quiet_fall("R11 line clamp in external mode", 20);
        run_ext(100, 500, 5);
        set_ctrl(0, 2, 0, 1);
        run_ext(0, 1023, 0);

        // R9 back to manual
        set_ctrl(0, 0, 1, 0);
        wr(2'd2, 10'd200);
        exp_off = 200;
        chk("R9 manual after auto", off_now(), 200);
        quiet_fall("R9 hold", 40);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule